// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This controller turns single-word read and write requests from a parallel command port into the bit-level traffic of a three-wire serial EEPROM. The EEPROM side has four pins: chip select, serial clock and data toward the memory, plus a data line coming back from it. The bit rate comes from a programmable divider. One divider tick is the basic time unit. A data bit takes three ticks: setup with the clock low, then clock high, then clock low. A bit that is read takes two ticks.

A read sends the read command and the address, then clocks in one 16-bit word. A write runs a longer chain on its own: write-enable, erase of the word, a wait for ready, programming of the word, a second wait for ready, then write-disable. Between commands, chip select drops for one tick. During each wait the memory's data line is polled once per tick. If it never goes high, the request ends with an error and nothing further is sent. A configuration pin chooses between a small part with 6 address bits and a larger part with 8 address bits.

Top module: `mw_eeprom_master`

## Requirements
- R1: A read sends the 3-bit field 110 and then the address, MSB first. The address is the low 6 bits of req_addr when cfg_big is 0, or all 8 bits when cfg_big is 1. All of this goes out in a single chip-select window.
- R2: After the address, a read gives 16 more clock pulses in the same window. It samples ee_do while the clock is high, MSB first. The word appears on rd_data when done pulses and stays there until the next accepted request.
- R3: A write opens six chip-select windows, in this order. (1) 10011 followed by dummy ones: 4 for the small part, 6 for the large part. (2) 111 plus the address. (3) A ready wait with no clock pulses. (4) 101 plus the address plus the 16 data bits. (5) Another ready wait. (6) 10000 followed by the same dummy ones.
- R4: ee_di changes only while ee_sk is low. Every high phase of ee_sk lasts exactly clk_div+1 clock cycles.
- R5: Between two windows of the same request, ee_cs stays low for exactly clk_div+1 cycles. A request that completes ends with one ee_sk pulse while ee_cs and ee_di are low.
- R6: In a ready wait, the block moves on only after it sees ee_do high. It then holds chip select for 6 more ticks before the standby that follows.
- R7: If ee_do is still low after 50000 polls, the request ends. done and error pulse together, ee_cs goes low, and no further clock pulse or window follows.
- R8: A request is accepted only while busy is low. Requests made while busy have no effect. done lasts one cycle. error is valid with done and is held until the next accepted request.
- R9: Out of reset, ee_cs, ee_sk, ee_di, busy, done and error are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_big | input | 1 | 0: 6-bit address part, 1: 8-bit address part |
| clk_div | input | DIV_W | Tick period minus one, in clock cycles |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_write | input | 1 | 1: write word, 0: read word |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Ready timeout on the last request |
| rd_data | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data toward the EEPROM |
| ee_do | input | 1 | Serial data / ready status from the EEPROM |

## Verification
Some properties are checked on every cycle: serial data stays still while the clock is high, the clock pulses only in the cleanup phase when select is low, done lasts one cycle and comes exactly when busy falls, error rises only together with done, and the poll count never passes its limit. Other behaviour needs the bench scenarios. These are the bit content and order of every window, the dummy-bit count for each part size, the returned word, the standby and clock-high widths for a given divider, the six-tick settle after ready, the abort after a timeout, and the ignored request during a busy run. The bench's memory model decodes these from the pins.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_SHOUT, ST_SHIN, ST_STBY, ST_POLL, ST_SETTLE, ST_CLEAN
  } mw_state_e;

  typedef enum logic [2:0] {
    OP_READ, OP_EN, OP_ERASE, OP_WRITE, OP_DIS
  } mw_op_e;

  localparam logic [2:0] OPC_READ  = 3'b110;
  localparam logic [2:0] OPC_WRITE = 3'b101;
  localparam logic [2:0] OPC_ERASE = 3'b111;
  localparam logic [4:0] OPC_EN    = 5'b10011;
  localparam logic [4:0] OPC_DIS   = 5'b10000;

  localparam int SMALL_AW = 6;
  localparam int LARGE_AW = 8;

endpackage

// File: rtl/mw_tick_div.sv
module mw_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == div);
    cnt_d = (!en || cnt_q == div) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || !$stable(div)));

endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic expired
);

  localparam int PW = $clog2(LIMIT + 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = (cnt_q == PW'(LIMIT - 1));
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_q + PW'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= PW'(LIMIT - 1));

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int POLL_MAX     = 50000,
  parameter int SETTLE_TICKS = 6,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [15:0]       rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int ADDR_W  = LARGE_AW;
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int CMAX    = (FRAME_W > SETTLE_TICKS) ? FRAME_W : SETTLE_TICKS;
  localparam int CNT_W   = $clog2(CMAX + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  mw_state_e            state_q, state_d;
  mw_op_e               op_q, op_d;
  logic [1:0]           ph_q, ph_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_W-1:0]   frame_q, frame_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [DATA_W-1:0]    wdata_q, wdata_d;
  logic                 big_q, big_d;
  logic                 polled_q, polled_d;
  logic                 cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic                 done_q, done_d, err_q, err_d;

  logic                 tick, poll_clr, poll_step, poll_exp;
  logic                 load;
  mw_op_e               nop;
  logic [FRAME_W-1:0]   ld_frame;
  logic [CNT_W-1:0]     ld_len;

  mw_tick_div #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_ni), .en(state_q != ST_IDLE), .div(clk_div), .tick(tick)
  );

  mw_poll_timer #(.LIMIT(POLL_MAX)) i_poll (
    .clk(clk), .rst_n(rst_ni), .clr(poll_clr), .step(poll_step), .expired(poll_exp)
  );

  // Frame for one command, right-aligned, with its bit length.
  function automatic logic [FRAME_W+CNT_W-1:0] build(
    input mw_op_e op, input logic big,
    input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] v, am, dm;
    int aw, dw, n;
    aw = big ? LARGE_AW : SMALL_AW;
    dw = aw - 2;
    am = (FRAME_W'(1) << aw) - FRAME_W'(1);
    dm = (FRAME_W'(1) << dw) - FRAME_W'(1);
    case (op)
      OP_READ:  begin v = (FRAME_W'(OPC_READ)  << aw) | (FRAME_W'(a) & am); n = 3 + aw; end
      OP_ERASE: begin v = (FRAME_W'(OPC_ERASE) << aw) | (FRAME_W'(a) & am); n = 3 + aw; end
      OP_WRITE: begin
        v = (((FRAME_W'(OPC_WRITE) << aw) | (FRAME_W'(a) & am)) << DATA_W) | FRAME_W'(d);
        n = 3 + aw + DATA_W;
      end
      OP_EN:    begin v = (FRAME_W'(OPC_EN)  << dw) | dm; n = 5 + dw; end
      default:  begin v = (FRAME_W'(OPC_DIS) << dw) | dm; n = 5 + dw; end
    endcase
    return {v, CNT_W'(n)};
  endfunction

  always_comb begin
    {ld_frame, ld_len} = build(nop, big_q, addr_q, wdata_q);
  end

  // next-state
  always_comb begin
    state_d = state_q;  op_d = op_q;  ph_d = ph_q;  cnt_d = cnt_q;
    frame_d = frame_q;  rdata_d = rdata_q;  addr_d = addr_q;  wdata_d = wdata_q;
    big_d = big_q;  polled_d = polled_q;
    cs_d = cs_q;  sk_d = sk_q;  di_d = di_q;
    done_d = 1'b0;  err_d = err_q;
    poll_clr = 1'b0;  poll_step = 1'b0;
    load = 1'b0;  nop = op_q;

    if (state_q == ST_IDLE) begin
      if (req_valid) begin
        big_d   = cfg_big;
        addr_d  = req_addr;
        wdata_d = req_wdata;
        op_d    = req_write ? OP_EN : OP_READ;
        err_d   = 1'b0;
        state_d = ST_SEL;
        cs_d = 1'b1;  sk_d = 1'b0;  di_d = 1'b0;
      end
    end else if (tick) begin
      case (state_q)
        ST_SEL: load = 1'b1;

        ST_SHOUT: begin
          case (ph_q)
            2'd0:    begin sk_d = 1'b1; ph_d = 2'd1; end
            2'd1:    begin sk_d = 1'b0; ph_d = 2'd2; end
            default: begin
              if (cnt_q == CNT_W'(1)) begin
                di_d = 1'b0;
                if (op_q == OP_READ) begin
                  state_d = ST_SHIN;  cnt_d = CNT_W'(DATA_W);  sk_d = 1'b1;  ph_d = 2'd1;
                end else if (op_q == OP_DIS) begin
                  state_d = ST_CLEAN;  cs_d = 1'b0;  ph_d = 2'd0;
                end else begin
                  state_d = ST_STBY;  cs_d = 1'b0;
                end
              end else begin
                cnt_d = cnt_q - CNT_W'(1);
                di_d  = frame_q[cnt_q - CNT_W'(2)];
                ph_d  = 2'd0;
              end
            end
          endcase
        end

        ST_SHIN: begin
          if (ph_q == 2'd1) begin
            rdata_d = {rdata_q[DATA_W-2:0], ee_do};
            sk_d = 1'b0;  ph_d = 2'd2;
          end else if (cnt_q == CNT_W'(1)) begin
            state_d = ST_CLEAN;  cs_d = 1'b0;  ph_d = 2'd0;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);  sk_d = 1'b1;  ph_d = 2'd1;
          end
        end

        ST_STBY: begin
          if ((op_q == OP_ERASE || op_q == OP_WRITE) && !polled_q) begin
            state_d = ST_POLL;  cs_d = 1'b1;  poll_clr = 1'b1;
          end else begin
            load = 1'b1;
            case (op_q)
              OP_EN:    nop = OP_ERASE;
              OP_ERASE: nop = OP_WRITE;
              default:  nop = OP_DIS;
            endcase
          end
        end

        ST_POLL: begin
          if (ee_do) begin
            state_d = ST_SETTLE;  cnt_d = CNT_W'(SETTLE_TICKS - 1);
          end else if (poll_exp) begin
            state_d = ST_IDLE;  cs_d = 1'b0;  done_d = 1'b1;  err_d = 1'b1;
          end else begin
            poll_step = 1'b1;
          end
        end

        ST_SETTLE: begin
          if (cnt_q == '0) begin
            state_d = ST_STBY;  cs_d = 1'b0;  polled_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end

        ST_CLEAN: begin
          case (ph_q)
            2'd0:    begin sk_d = 1'b1; ph_d = 2'd1; end
            2'd1:    begin sk_d = 1'b0; ph_d = 2'd2; end
            default: begin state_d = ST_IDLE; done_d = 1'b1; end
          endcase
        end

        default: state_d = ST_IDLE;
      endcase

      if (load) begin
        state_d  = ST_SHOUT;
        op_d     = nop;
        frame_d  = ld_frame;
        cnt_d    = ld_len;
        ph_d     = 2'd0;
        polled_d = 1'b0;
        cs_d = 1'b1;  sk_d = 1'b0;
        di_d = ld_frame[ld_len - CNT_W'(1)];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  op_q <= OP_READ;  ph_q <= '0;  cnt_q <= '0;
      frame_q <= '0;  rdata_q <= '0;  addr_q <= '0;  wdata_q <= '0;
      big_q <= 1'b0;  polled_q <= 1'b0;
      cs_q <= 1'b0;  sk_q <= 1'b0;  di_q <= 1'b0;
      done_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      state_q <= state_d;  op_q <= op_d;  ph_q <= ph_d;  cnt_q <= cnt_d;
      frame_q <= frame_d;  rdata_q <= rdata_d;  addr_q <= addr_d;  wdata_q <= wdata_d;
      big_q <= big_d;  polled_q <= polled_d;
      cs_q <= cs_d;  sk_q <= sk_d;  di_q <= di_d;
      done_q <= done_d;  err_q <= err_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign error   = err_q;
  assign rd_data = rdata_q;
  assign ee_cs   = cs_q;
  assign ee_sk   = sk_q;
  assign ee_di   = di_q;

  // R4
  di_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sk_q && $past(sk_q)) |-> $stable(di_q));

  // R5
  sk_deselect_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($rose(sk_q) && !cs_q) |-> (state_q == ST_CLEAN && !di_q));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  done_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done_q);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(err_q) |-> done_q);

  // R9
  always @(posedge clk) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!cs_q && !sk_q && !di_q && !done_q);
    end
  end

endmodule

// File: tb/test_mw_eeprom_master.sv
module test_mw_eeprom_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = 8'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        busy, done, error;
  logic [15:0] rd_data;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  always #2 clk = ~clk;

  mw_eeprom_master i_mw_eeprom_master (
    .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .clk_div(clk_div),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .error(error),
    .rd_data(rd_data), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  int          aw;
  int          nbits;
  logic [63:0] sval;
  bit          is_rd;
  logic [15:0] rd_word;
  logic        rd_bit = 1'b0;
  bit          pgm_pending = 1'b0;
  int          ready_cnt = 0;
  int          ready_delay = 0;
  int          lowclk = 0;
  int          nb_q[$];
  logic [63:0] sv_q[$];

  assign ee_do = ee_cs && (is_rd && nbits >= 3 + aw ? rd_bit
                 : (pgm_pending && ready_delay >= 0 && ready_cnt >= ready_delay));

  always @(posedge ee_cs) begin
    nbits = 0; sval = '0; is_rd = 1'b0;
  end

  always @(negedge ee_cs) begin
    nb_q.push_back(nbits);
    sv_q.push_back(sval);
    if (nbits >= 3 && (sval >> (nbits - 3)) != 64'd6 && (sval >> (nbits - 3)) >= 64'd5
        && nbits <= 3 + aw + 16 && (sval >> (nbits - 3)) <= 64'd7) begin
      pgm_pending = 1'b1; ready_cnt = 0;
    end
    is_rd = 1'b0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (is_rd && nbits >= 3 + aw && nbits < 3 + aw + 16)
        rd_bit = rd_word[15 - (nbits - 3 - aw)];
      sval = (sval << 1) | 64'(ee_di);
      nbits++;
      if (nbits == 3) is_rd = (sval[2:0] == 3'b110);
      pgm_pending = 1'b0;
    end else begin
      lowclk++;
    end
  end

  always @(posedge clk) if (pgm_pending) ready_cnt++;

  // ---------------- per-cycle timing monitors ----------------
  int  skrun = 0, skbad = 0, gap = 0, gapbad = 0, done_cnt = 0;
  int  lat = 0, lat_bad = 0, lat_seen = 0;
  bit  lat_run = 1'b0, lat_done = 1'b0;
  bit  di_bad = 1'b0;
  logic prev_sk = 1'b0, prev_di = 1'b0;

  always @(negedge clk) begin
    cycles++;
    if (done) done_cnt++;
    if (ee_sk) skrun++;
    else if (skrun > 0) begin
      if (skrun != int'(clk_div) + 1) skbad++;
      skrun = 0;
    end
    if (!busy) gap = 0;
    else if (!ee_cs) gap++;
    else if (gap > 0) begin
      if (gap != int'(clk_div) + 1) gapbad++;
      gap = 0;
    end
    if (ee_sk && prev_sk && ee_di != prev_di) di_bad = 1'b1;
    prev_sk = ee_sk; prev_di = ee_di;
    if (!pgm_pending) lat_done = 1'b0;
    if (pgm_pending && ee_do && !lat_run && !lat_done) begin
      lat_run = 1'b1; lat = 0;
    end
    if (lat_run) begin
      if (!ee_cs) begin
        lat_run = 1'b0; lat_done = 1'b1; lat_seen++;
        if (lat < 6 * (int'(clk_div) + 1) || lat > 8 * (int'(clk_div) + 1) + 2) lat_bad++;
      end else lat++;
    end
  end

  // ---------------- helpers ----------------
  task automatic clear_model();
    nb_q.delete(); sv_q.delete();
    lowclk = 0; skbad = 0; gapbad = 0; done_cnt = 0;
    lat_bad = 0; lat_seen = 0; di_bad = 1'b0;
  endtask

  task automatic run_req(input bit wr, input logic [7:0] a, input logic [15:0] d,
                         input bit poke_busy);
    int n;
    aw = cfg_big ? 8 : 6;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 120000) begin
      @(negedge clk);
      n++;
      if (poke_busy && n == 40) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h3C;
      end
      if (poke_busy && n == 43) req_valid = 1'b0;
    end
    check(done, "R8 done seen", done, 1);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] en_val(input int dw, input logic [4:0] opc);
    return (64'(opc) << dw) | ((64'd1 << dw) - 1);
  endfunction

  task automatic check_write(input logic [7:0] a, input logic [15:0] d);
    int dw;
    logic [63:0] am;
    int          exp_n[6];
    logic [63:0] exp_v[6];
    dw = aw - 2;
    am = (64'd1 << aw) - 1;
    exp_n = '{5 + dw, 3 + aw, 0, 3 + aw + 16, 0, 5 + dw};
    exp_v[0] = en_val(dw, 5'b10011);
    exp_v[1] = (64'd7 << aw) | (64'(a) & am);
    exp_v[2] = 64'd0;
    exp_v[3] = (((64'd5 << aw) | (64'(a) & am)) << 16) | 64'(d);
    exp_v[4] = 64'd0;
    exp_v[5] = en_val(dw, 5'b10000);
    check(nb_q.size() == 6, "R3 window count", nb_q.size(), 6);
    if (nb_q.size() == 6) begin
      for (int i = 0; i < 6; i++) begin
        check(nb_q[i] == exp_n[i], "R3 window length", nb_q[i], exp_n[i]);
        check(sv_q[i] == exp_v[i], "R3 window bits", sv_q[i], exp_v[i]);
      end
    end
    check(error == 1'b0, "R8 no error", error, 0);
    check(gapbad == 0, "R5 standby width", gapbad, 0);
    check(lowclk == 1, "R5 cleanup pulse", lowclk, 1);
    check(skbad == 0, "R4 clock high width", skbad, 0);
    check(!di_bad, "R4 data held while clock high", di_bad, 0);
    check(lat_seen == 2 && lat_bad == 0, "R6 settle after ready", lat_bad, 0);
  endtask

  task automatic check_read(input logic [7:0] a, input logic [15:0] w);
    logic [63:0] exp;
    exp = (64'd6 << aw) | (64'(a) & ((64'd1 << aw) - 1));
    check(nb_q.size() == 1, "R1 one window", nb_q.size(), 1);
    if (nb_q.size() == 1) begin
      check(nb_q[0] == 3 + aw + 16, "R2 clock count", nb_q[0], 3 + aw + 16);
      check((sv_q[0] >> 16) == exp, "R1 opcode and address", sv_q[0] >> 16, exp);
    end
    check(rd_data == w, "R2 read word", rd_data, w);
    check(lowclk == 1, "R5 cleanup pulse", lowclk, 1);
    check(skbad == 0, "R4 clock high width", skbad, 0);
  endtask

  // watchdog
  initial begin
    wait (cycles > 190000);
    check(1'b0, "watchdog", cycles, 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    aw = 6;
    repeat (3) @(negedge clk);
    // R9 reset state
    check({ee_cs, ee_sk, ee_di, busy, done, error} == 6'b0, "R9 reset outputs",
          {ee_cs, ee_sk, ee_di, busy, done, error}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !ee_cs, "R9 idle after release", busy, 0);

    // R1 R2 small read, divider 1
    cfg_big = 1'b0; clk_div = 8'd1; rd_word = 16'hA55A; clear_model();
    run_req(1'b0, 8'h2A, 16'h0000, 1'b0);
    check_read(8'h2A, 16'hA55A);

    // R1 R2 large read, divider 0
    cfg_big = 1'b1; clk_div = 8'd0; rd_word = 16'h1234; clear_model();
    run_req(1'b0, 8'hC3, 16'h0000, 1'b0);
    check_read(8'hC3, 16'h1234);

    // R3 R5 R6 small write
    cfg_big = 1'b0; clk_div = 8'd2; ready_delay = 5; clear_model();
    run_req(1'b1, 8'h15, 16'hBEEF, 1'b0);
    check_write(8'h15, 16'hBEEF);
    check(rd_data == 16'h1234, "R2 read word held", rd_data, 16'h1234);

    // R3 large write, with an ignored request while busy (R8)
    cfg_big = 1'b1; clk_div = 8'd0; ready_delay = 12; clear_model();
    run_req(1'b1, 8'hA7, 16'h0F0F, 1'b1);
    check_write(8'hA7, 16'h0F0F);
    check(done_cnt == 1, "R8 ignored request while busy", done_cnt, 1);

    // R7 timeout
    cfg_big = 1'b0; clk_div = 8'd0; ready_delay = -1; clear_model();
    run_req(1'b1, 8'h09, 16'h5555, 1'b0);
    check(error == 1'b1, "R7 error flag", error, 1);
    check(nb_q.size() == 3, "R7 no later windows", nb_q.size(), 3);
    check(lowclk == 0, "R7 no cleanup pulse", lowclk, 0);
    check(!ee_cs && !busy, "R7 deselected", ee_cs, 0);

    // R8 error cleared by next request
    cfg_big = 1'b0; clk_div = 8'd0; ready_delay = 3; rd_word = 16'h00FF; clear_model();
    run_req(1'b0, 8'h3F, 16'h0000, 1'b0);
    check(error == 1'b0, "R8 error cleared", error, 0);
    check_read(8'h3F, 16'h00FF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule